// File: doc/BRIEF.md
# Clock Divider Factor Calculator

This block works out the 8-bit integer factor that an output clock divider should be loaded with so that its output frequency comes as close as possible to a requested frequency. A request carries a parent frequency, a requested frequency and a command code. For a set command, the block divides the parent frequency by the request with a restoring shift-subtract divider. That truncated quotient is the first candidate factor. The block then divides the parent frequency by the candidate and by the candidate plus one. It keeps whichever factor gives the nearer output, and a tie goes to the larger factor. A result above 255 is clamped to 255 and flagged. A zero result is flagged and never stored.

The stored factor is the block's one piece of state. A zero factor means the output clock is off, and an off command writes that zero. A read command reuses the divider to report the frequency that the stored factor actually achieves from a given parent frequency. The requested frequency is ignored on read and off commands. Producing the divided clock edges is left to the divider that consumes the factor.

Requests use a valid/ready handshake. A request transfers on a clock edge where both `req_valid_i` and `req_ready_o` are high. The requester must hold valid and the request fields steady until that edge. Ready stays low from acceptance until the cycle after the completion pulse. A request offered while ready is low is not taken, and it has no effect. Completion is a plain one-cycle `done_o` pulse with no back-pressure, so the consumer must capture the factor, the rate and the flags in that cycle.

Top module: `clkdiv_calc`

## Requirements
- R1: After reset, `factor_o` is 0, `rate_o` is 0, `done_o`, `err_ovf_o` and `err_unf_o` are 0, and `req_ready_o` is 1.
- R2: A request is accepted only on an edge where valid and ready are both high. Ready is low while an operation runs and during the done cycle. A request offered while ready is low is ignored and changes neither the result nor the stored factor. Command codes: 0 = set, 1 = read, 2 and 3 = off.
- R3: For a set command with requested frequency R > 0 and parent frequency P, let q = floor(P/R), with 1 <= q <= 255. The stored factor becomes q+1 when |R - floor(P/(q+1))| <= |R - floor(P/q)|, and q otherwise. Ties therefore go to the larger factor.
- R4: When the chosen factor, or q itself, exceeds 255, the stored factor becomes 255 and `err_ovf_o` is 1 in the done cycle.
- R5: When q = 0 (R > P), `err_unf_o` is 1 in the done cycle and the stored factor keeps its previous value.
- R6: A set command with R = 0 completes with `done_o` and `err_unf_o` high in the cycle after the acceptance edge, without running a division, and leaves the stored factor unchanged.
- R7: An off command (code 2 or 3) sets the stored factor to 0, with `done_o` high in the cycle after acceptance.
- R8: A read command sets `rate_o` to floor(P / stored factor) using the parent frequency given with the read. When the stored factor is 0, `rate_o` becomes 0 and `done_o` rises in the cycle after acceptance.
- R9: `done_o` is high for exactly one cycle per accepted request. `err_ovf_o` and `err_unf_o` are high only in a done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle and able to take a request |
| req_cmd_i | input | 2 | Command: 0 set, 1 read, 2/3 off |
| parent_freq_i | input | FREQ_W | Parent clock frequency |
| req_freq_i | input | FREQ_W | Requested output frequency (set only) |
| done_o | output | 1 | One-cycle completion pulse |
| factor_o | output | FACT_W | Stored divider factor, 0 = clock off |
| rate_o | output | FREQ_W | Achieved frequency from the last read |
| err_ovf_o | output | 1 | Factor clamped to 255 (with done) |
| err_unf_o | output | 1 | Factor would be zero, not stored (with done) |

## Verification
On every cycle, the assertions check the following: the done pulse lasts a single cycle, and the flags appear only with it. An overflow always leaves 255 stored, and an underflow never disturbs the stored factor. A refused request leaves the latched operands alone. The immediate paths (zero request, off, reading a zero factor) finish on the next cycle. Inside the divider, the assertions check that the remainder ends below the divisor and that no start arrives while it is busy. Only the bench's scenarios show the following: that the nearest-output choice and the tie rule pick the right factor for concrete frequencies, the clamp when rounding crosses 255, and that read-back rates match the stored factor.

// File: rtl/clkdiv_calc_pkg.sv
package clkdiv_calc_pkg;

  typedef enum logic [1:0] {
    CMD_SET  = 2'd0,
    CMD_READ = 2'd1,
    CMD_OFF  = 2'd2,
    CMD_OFF2 = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUOT,
    ST_NEAR_LO,
    ST_NEAR_HI,
    ST_RATE
  } state_e;

endpackage

// File: rtl/clkdiv_restoring_div.sv
module clkdiv_restoring_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [W:0]    shifted;
  logic [W+1:0]  trial;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = {1'b0, shifted} - {2'b00, den_q};
    fits    = !trial[W+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        rem_q  <= '0;
        quo_q  <= dividend_i;
        den_q  <= divisor_i;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= fits ? trial[W-1:0] : shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quot_o = quo_q;

  // Remainder left below the divisor proves the quotient is the truncated one (R3)
  assert_rem_below_den_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (den_q == '0 || rem_q < den_q));

  // The controller never restarts a division in flight (R2)
  assert_no_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);

endmodule

// File: rtl/clkdiv_nearest_pick.sv
module clkdiv_nearest_pick #(
  parameter int W = 32
) (
  input  logic [W-1:0] target_i,
  input  logic [W-1:0] out_small_div_i,
  input  logic [W-1:0] out_large_div_i,
  output logic         pick_large_o
);
  logic [W-1:0] dist_small, dist_large;

  always_comb begin
    dist_small = (target_i > out_small_div_i) ? target_i - out_small_div_i
                                              : out_small_div_i - target_i;
    dist_large = (target_i > out_large_div_i) ? target_i - out_large_div_i
                                              : out_large_div_i - target_i;
    pick_large_o = (dist_large <= dist_small);
  end

endmodule

// File: rtl/clkdiv_calc.sv
module clkdiv_calc
  import clkdiv_calc_pkg::*;
#(
  parameter int FREQ_W = 32,
  parameter int FACT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_cmd_i,
  input  logic [FREQ_W-1:0] parent_freq_i,
  input  logic [FREQ_W-1:0] req_freq_i,
  output logic              done_o,
  output logic [FACT_W-1:0] factor_o,
  output logic [FREQ_W-1:0] rate_o,
  output logic              err_ovf_o,
  output logic              err_unf_o
);
  localparam logic [FREQ_W-1:0] FACT_MAX = FREQ_W'((1 << FACT_W) - 1);
  localparam logic [FACT_W-1:0] FACT_SAT = '1;

  state_e            state_q;
  logic [FREQ_W-1:0] parent_q, req_q, cand_q, out_lo_q, rate_q, div_den_q;
  logic [FACT_W-1:0] factor_q;
  logic              done_q, ovf_q, unf_q, div_start_q;
  logic              div_busy, div_done, pick_large;
  logic [FREQ_W-1:0] div_quot, chosen;
  logic              accept;
  cmd_e              cmd;

  assign cmd         = cmd_e'(req_cmd_i);
  assign req_ready_o = (state_q == ST_IDLE) && !done_q;
  assign accept      = req_valid_i && req_ready_o;

  clkdiv_restoring_div #(.W(FREQ_W)) div_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start_q),
    .dividend_i (parent_q),
    .divisor_i  (div_den_q),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  clkdiv_nearest_pick #(.W(FREQ_W)) pick_i (
    .target_i        (req_q),
    .out_small_div_i (out_lo_q),
    .out_large_div_i (div_quot),
    .pick_large_o    (pick_large)
  );

  assign chosen = pick_large ? cand_q + FREQ_W'(1) : cand_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      parent_q    <= '0;
      req_q       <= '0;
      cand_q      <= '0;
      out_lo_q    <= '0;
      rate_q      <= '0;
      div_den_q   <= '0;
      factor_q    <= '0;
      done_q      <= 1'b0;
      ovf_q       <= 1'b0;
      unf_q       <= 1'b0;
      div_start_q <= 1'b0;
    end else begin
      done_q      <= 1'b0;
      ovf_q       <= 1'b0;
      unf_q       <= 1'b0;
      div_start_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          parent_q <= parent_freq_i;
          req_q    <= req_freq_i;
          case (cmd)
            CMD_SET: begin
              if (req_freq_i == '0) begin
                done_q <= 1'b1;
                unf_q  <= 1'b1;
              end else begin
                div_den_q   <= req_freq_i;
                div_start_q <= 1'b1;
                state_q     <= ST_QUOT;
              end
            end
            CMD_READ: begin
              if (factor_q == '0) begin
                rate_q <= '0;
                done_q <= 1'b1;
              end else begin
                div_den_q   <= {{(FREQ_W-FACT_W){1'b0}}, factor_q};
                div_start_q <= 1'b1;
                state_q     <= ST_RATE;
              end
            end
            default: begin
              factor_q <= '0;
              done_q   <= 1'b1;
            end
          endcase
        end
        ST_QUOT: if (div_done) begin
          cand_q <= div_quot;
          if (div_quot == '0) begin
            unf_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (div_quot > FACT_MAX) begin
            factor_q <= FACT_SAT;
            ovf_q    <= 1'b1;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            div_den_q   <= div_quot;
            div_start_q <= 1'b1;
            state_q     <= ST_NEAR_LO;
          end
        end
        ST_NEAR_LO: if (div_done) begin
          out_lo_q    <= div_quot;
          div_den_q   <= cand_q + FREQ_W'(1);
          div_start_q <= 1'b1;
          state_q     <= ST_NEAR_HI;
        end
        ST_NEAR_HI: if (div_done) begin
          if (chosen > FACT_MAX) begin
            factor_q <= FACT_SAT;
            ovf_q    <= 1'b1;
          end else begin
            factor_q <= chosen[FACT_W-1:0];
          end
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_RATE: if (div_done) begin
          rate_q  <= div_quot;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o    = done_q;
  assign factor_o  = factor_q;
  assign rate_o    = rate_q;
  assign err_ovf_o = ovf_q;
  assign err_unf_o = unf_q;

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_flag_needs_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q || unf_q) |-> done_q);

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> factor_q == FACT_SAT);

  assert_unf_keeps_factor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |-> $stable(factor_q));

  assert_refused_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |=> $stable(req_q));

  assert_zero_req_fast_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmd == CMD_SET && req_freq_i == '0) |=> (done_q && unf_q));

  assert_off_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_cmd_i[1]) |=> (done_q && factor_q == '0));

  assert_read_off_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmd == CMD_READ && factor_q == '0) |=> (done_q && rate_q == '0));

  assert_divider_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !div_busy);

endmodule

// File: tb/clkdiv_calc_tb_top.sv
`timescale 1ns/1ps
module clkdiv_calc_tb_top;
  localparam int FREQ_W = 32;
  localparam int FACT_W = 8;
  localparam int NVEC   = 12;

  localparam logic [FREQ_W-1:0] VEC_P [NVEC] = '{
    32'd100, 32'd100, 32'd100, 32'd1000000, 32'd1000000, 32'd2550,
    32'd1000, 32'd10, 32'd48000000, 32'd33333333, 32'd600000000, 32'hFFFFFFFF};
  localparam logic [FREQ_W-1:0] VEC_R [NVEC] = '{
    32'd30, 32'd28, 32'd29, 32'd3913, 32'd3914, 32'd10,
    32'd3, 32'd20, 32'd1000000, 32'd25000000, 32'd7, 32'hFFFFFFFF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_cmd = 2'd0;
  logic [FREQ_W-1:0] parent_freq = '0, req_freq = '0;
  logic req_ready, done, err_ovf, err_unf;
  logic [FACT_W-1:0] factor;
  logic [FREQ_W-1:0] rate;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int exp_factor = 0;
  int waited;
  logic c_ovf, c_unf;
  logic [FACT_W-1:0] c_factor;
  logic [FREQ_W-1:0] c_rate;

  always #4 clk = ~clk;

  clkdiv_calc #(.FREQ_W(FREQ_W), .FACT_W(FACT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_cmd_i(req_cmd), .parent_freq_i(parent_freq), .req_freq_i(req_freq),
    .done_o(done), .factor_o(factor), .rate_o(rate),
    .err_ovf_o(err_ovf), .err_unf_o(err_unf));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Expected factor of a set command, written from R3..R6
  task automatic model_set(input longint p, input longint r,
                           output int fac, output bit ovf, output bit unf);
    longint q, a, b, da, db, pick;
    ovf = 0; unf = 0; fac = exp_factor;
    if (r == 0) begin unf = 1; return; end
    q = p / r;
    if (q == 0) begin unf = 1; return; end
    if (q > 255) begin ovf = 1; fac = 255; return; end
    a = p / q; b = p / (q + 1);
    da = (r > a) ? r - a : a - r;
    db = (r > b) ? r - b : b - r;
    pick = (db <= da) ? q + 1 : q;
    if (pick > 255) begin ovf = 1; fac = 255; end
    else fac = int'(pick);
  endtask

  // Issue one request, wait for done, capture outputs; waited = negedges after acceptance
  task automatic run_op(input logic [1:0] c, input logic [FREQ_W-1:0] p, input logic [FREQ_W-1:0] r);
    @(negedge clk);
    req_cmd = c; parent_freq = p; req_freq = r; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!done && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    check(done == 1'b1, "R9 done seen", waited, 0);
    c_ovf = err_ovf; c_unf = err_unf; c_factor = factor; c_rate = rate;
  endtask

  initial begin
    int ef;
    bit eo, eu;
    repeat (3) @(negedge clk);
    check(factor == 0, "R1 factor", factor, 0);
    check(rate == 0, "R1 rate", rate, 0);
    check(done == 0 && err_ovf == 0 && err_unf == 0, "R1 pulses", {done, err_ovf, err_unf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1, "R1 ready", req_ready, 1);

    // R8: reading with the clock off reports zero at once
    run_op(2'd1, 32'd500, 32'd0);
    check(waited == 0, "R8 immediate read", waited, 0);
    check(c_rate == 0, "R8 off rate", c_rate, 0);

    // Vector table: set, then read back the achieved frequency (R3 R4 R5 R8)
    for (int i = 0; i < NVEC; i++) begin
      model_set(longint'(VEC_P[i]), longint'(VEC_R[i]), ef, eo, eu);
      run_op(2'd0, VEC_P[i], VEC_R[i]);
      exp_factor = ef;
      check(c_factor == ef, "R3 factor", c_factor, ef);
      check(c_ovf == eo, "R4 overflow flag", c_ovf, eo);
      check(c_unf == eu, "R5 underflow flag", c_unf, eu);
      run_op(2'd1, VEC_P[i], 32'd0);
      check(c_rate == ((ef == 0) ? 0 : longint'(VEC_P[i]) / ef), "R8 readback",
            c_rate, (ef == 0) ? 0 : longint'(VEC_P[i]) / ef);
    end

    // Directed: tie goes to larger factor, 100/29 -> 4 (R3)
    run_op(2'd0, 32'd100, 32'd29);
    check(c_factor == 4, "R3 tie larger", c_factor, 4);
    // Rounding past 255 clamps with overflow (R4)
    run_op(2'd0, 32'd1000000, 32'd3913);
    check(c_factor == 255 && c_ovf == 1, "R4 round clamp", c_factor, 255);
    // Request above parent: underflow, factor kept at 255 (R5)
    run_op(2'd0, 32'd10, 32'd20);
    check(c_unf == 1 && c_factor == 255, "R5 keep factor", c_factor, 255);
    // Zero request finishes in the next cycle (R6)
    run_op(2'd0, 32'd100, 32'd0);
    check(waited == 0 && c_unf == 1, "R6 zero request", waited, 0);
    check(c_factor == 255, "R6 factor unchanged", c_factor, 255);
    // Read uses parent given with the read (R8)
    run_op(2'd0, 32'd100, 32'd28);
    check(c_factor == 4, "R3 nearest", c_factor, 4);
    run_op(2'd1, 32'd1000, 32'd0);
    check(c_rate == 250, "R8 other parent", c_rate, 250);

    // Busy requests are ignored (R2)
    @(negedge clk);
    req_cmd = 2'd0; parent_freq = 32'd100; req_freq = 32'd30; req_valid = 1'b1;
    @(negedge clk);
    req_cmd = 2'd2;
    for (int k = 0; k < 5; k++) begin
      check(req_ready == 0, "R2 ready low busy", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    waited = 0;
    while (!done && waited < 400) begin @(negedge clk); waited++; end
    check(factor == 3, "R2 busy off ignored", factor, 3);
    check(req_ready == 0, "R2 ready low in done", req_ready, 0);
    @(negedge clk);
    check(done == 0, "R9 single pulse", done, 0);
    check(factor == 3, "R2 still set", factor, 3);

    // Off commands, both codes (R7)
    run_op(2'd2, 32'd100, 32'd0);
    check(c_factor == 0 && waited == 0, "R7 off code 2", c_factor, 0);
    run_op(2'd0, 32'd100, 32'd50);
    check(c_factor == 2, "R3 exact", c_factor, 2);
    run_op(2'd3, 32'd100, 32'd0);
    check(c_factor == 0, "R7 off code 3", c_factor, 0);
    run_op(2'd1, 32'd100, 32'd0);
    check(c_rate == 0, "R8 read after off", c_rate, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule